// File: doc/BRIEF.md
# Top-P Smallest Score Tracker

This block watches a stream of matching costs produced for one reference segment while a search frame is scanned. Every input beat carries a cost and the (x, y) position of the candidate it belongs to. The block keeps the P lowest costs seen so far, sorted so that slot 0 holds the cheapest. Each slot also holds the matching position. One beat is absorbed per cycle. A comparator per slot decides whether that slot keeps its entry, takes the entry of the slot above it, or takes the new beat.

When the scan of the frame ends, the controller raises a done strobe together with the reference position. The block then converts each stored position into a signed displacement: stored position minus reference position. It presents the P displacements ranked best to worst, each with a flag saying whether the slot was ever filled. The slots are emptied at the same moment, so the next frame starts clean. A downstream voter combines the ranked lists of several segments. That voter sits outside this block.

Top module: `topk_score_tracker`

## Requirements
- R1: After reset, out_valid is 0, every out_ok bit is 0, every displacement output is 0, and every slot is empty with its cost at the all-ones value.
- R2: A beat enters the list only when its cost is strictly less than the cost held in at least one slot. A beat whose cost equals the all-ones maximum is never stored.
- R3: Stored costs stay in non-decreasing order from slot 0 to slot P-1. Output rank 0 (lowest bits of out_dx/out_dy, bit 0 of out_ok) is the lowest cost.
- R4: When a beat is placed at rank i, the entries at ranks i..P-2 move down one rank with their positions, and the entry at rank P-1 is dropped. The ranks above i are untouched.
- R5: A later beat with a cost equal to a stored cost ranks after the earlier one, so among equal costs the earliest arrivals are kept.
- R6: For a filled slot, the displacement is stored x minus ref_x and stored y minus ref_y, as two's complement values of COORD_W+1 bits. Rank r occupies bits [r*(COORD_W+1) +: COORD_W+1] of out_dx and out_dy.
- R7: A slot that holds no entry at done time reports out_ok bit 0 and a displacement of 0 in both axes. Filled slots form a prefix of the ranks.
- R8: A cycle with frame_done high makes out_valid high for exactly the following cycle. The ranked outputs are held until the next frame_done.
- R9: A beat presented with in_valid in the same cycle as frame_done is ignored. After a frame_done every slot is empty, so the next frame starts with no carried-over entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A cost beat is present |
| in_score | input | SCORE_W | Matching cost of the candidate |
| in_x | input | COORD_W | Candidate x position |
| in_y | input | COORD_W | Candidate y position |
| ref_x | input | COORD_W | Reference x position, sampled with frame_done |
| ref_y | input | COORD_W | Reference y position, sampled with frame_done |
| frame_done | input | 1 | End of search frame: publish and clear |
| out_valid | output | 1 | One-cycle strobe: ranked results updated |
| out_ok | output | NUM_SLOTS | Per-rank filled flag |
| out_dx | output | NUM_SLOTS*(COORD_W+1) | Per-rank signed x displacement |
| out_dy | output | NUM_SLOTS*(COORD_W+1) | Per-rank signed y displacement |

## Verification
The bench builds the tracker with three slots, 4-bit costs and 3-bit positions. At that size the 16 cost values cover every tie, the maximum cost and every relative order, and the 4-bit displacements reach both signed extremes, -7 and +7. Hundreds of random frames of 1 to 12 beats, plus directed frames (ascending, descending, all-equal, under-filled, all-maximum, and a beat colliding with done), are checked rank by rank. The expected list is built by selecting the cheapest remaining beat in arrival order.

// File: rtl/topk_pkg.sv
package topk_pkg;

    // Per-slot update decision taken each cycle
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_SHIFT  = 2'd1,
        ACT_INSERT = 2'd2
    } slot_act_e;

endpackage

// File: rtl/topk_slot_ctrl.sv
module topk_slot_ctrl
    import topk_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int SCORE_W   = 8
) (
    input  logic                         in_valid,
    input  logic [SCORE_W-1:0]           in_score,
    input  logic [NUM_SLOTS*SCORE_W-1:0] score_flat,
    output slot_act_e [NUM_SLOTS-1:0]    act
);

    logic [NUM_SLOTS-1:0] beats;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // strict compare: equal cost never displaces an older entry
        assign beats[g] = in_valid && (in_score < score_flat[g*SCORE_W +: SCORE_W]);
        if (g == 0) begin : g_head
            assign act[g] = beats[g] ? ACT_INSERT : ACT_HOLD;
        end else begin : g_rest
            assign act[g] = !beats[g]    ? ACT_HOLD  :
                            beats[g-1]   ? ACT_SHIFT : ACT_INSERT;
        end
    end

endmodule

// File: rtl/topk_mv_sub.sv
module topk_mv_sub #(
    parameter int COORD_W = 6
) (
    input  logic               filled,
    input  logic [COORD_W-1:0] pos,
    input  logic [COORD_W-1:0] ref_pos,
    output logic [COORD_W:0]   disp
);

    // widen by one bit so the difference is a proper two's complement value
    assign disp = filled ? ({1'b0, pos} - {1'b0, ref_pos}) : '0;

endmodule

// File: rtl/topk_score_tracker.sv
module topk_score_tracker
    import topk_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int SCORE_W   = 8,
    parameter int COORD_W   = 6,
    localparam int MV_W     = COORD_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [SCORE_W-1:0]        in_score,
    input  logic [COORD_W-1:0]        in_x,
    input  logic [COORD_W-1:0]        in_y,
    input  logic [COORD_W-1:0]        ref_x,
    input  logic [COORD_W-1:0]        ref_y,
    input  logic                      frame_done,
    output logic                      out_valid,
    output logic [NUM_SLOTS-1:0]      out_ok,
    output logic [NUM_SLOTS*MV_W-1:0] out_dx,
    output logic [NUM_SLOTS*MV_W-1:0] out_dy
);

    typedef struct packed {
        logic [SCORE_W-1:0] score;
        logic               filled;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } slot_t;

    typedef struct packed {
        slot_t [NUM_SLOTS-1:0]           slots;
        logic                            pub;
        logic [NUM_SLOTS-1:0]            ok;
        logic [NUM_SLOTS-1:0][MV_W-1:0]  dx;
        logic [NUM_SLOTS-1:0][MV_W-1:0]  dy;
    } state_t;

    localparam slot_t EMPTY_SLOT = '{score: '1, filled: 1'b0, x: '0, y: '0};

    state_t st_d, st_q, reset_st;

    logic [NUM_SLOTS*SCORE_W-1:0]    score_flat;
    logic [NUM_SLOTS-1:0]            vld_vec;
    slot_t [NUM_SLOTS-1:0]           above;
    slot_act_e [NUM_SLOTS-1:0]       act;
    logic [NUM_SLOTS-1:0][MV_W-1:0]  dx_w;
    logic [NUM_SLOTS-1:0][MV_W-1:0]  dy_w;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_view
        assign score_flat[g*SCORE_W +: SCORE_W] = st_q.slots[g].score;
        assign vld_vec[g] = st_q.slots[g].filled;
        if (g == 0) begin : g_top
            assign above[g] = EMPTY_SLOT;
        end else begin : g_low
            assign above[g] = st_q.slots[g-1];
        end

        topk_mv_sub #(.COORD_W(COORD_W)) u_sub_x (
            .filled  (st_q.slots[g].filled),
            .pos     (st_q.slots[g].x),
            .ref_pos (ref_x),
            .disp    (dx_w[g])
        );
        topk_mv_sub #(.COORD_W(COORD_W)) u_sub_y (
            .filled  (st_q.slots[g].filled),
            .pos     (st_q.slots[g].y),
            .ref_pos (ref_y),
            .disp    (dy_w[g])
        );
    end

    topk_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SCORE_W(SCORE_W)) u_ctrl (
        .in_valid   (in_valid && !frame_done),
        .in_score   (in_score),
        .score_flat (score_flat),
        .act        (act)
    );

    always_comb begin
        reset_st = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            reset_st.slots[i] = EMPTY_SLOT;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.pub = 1'b0;
        if (frame_done) begin
            st_d.pub = 1'b1;
            st_d.ok  = vld_vec;
            st_d.dx  = dx_w;
            st_d.dy  = dy_w;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                st_d.slots[i] = EMPTY_SLOT;
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                case (act[i])
                    ACT_SHIFT:  st_d.slots[i] = above[i];
                    ACT_INSERT: st_d.slots[i] = '{score: in_score, filled: 1'b1,
                                                  x: in_x, y: in_y};
                    default:    st_d.slots[i] = st_q.slots[i];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_st;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.pub;
    assign out_ok    = st_q.ok;
    assign out_dx    = st_q.dx;
    assign out_dy    = st_q.dy;

endmodule

// File: rtl/topk_checker.sv
module topk_checker #(
    parameter int NUM_SLOTS = 3,
    parameter int SCORE_W   = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic [SCORE_W-1:0]           in_score,
    input logic                         frame_done,
    input logic                         out_valid,
    input logic [NUM_SLOTS*SCORE_W-1:0] score_flat,
    input logic [NUM_SLOTS-1:0]         vld_vec
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        assert_empty_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_vec[g] |-> (score_flat[g*SCORE_W +: SCORE_W] == {SCORE_W{1'b1}}));
        if (g > 0) begin : g_pair
            assert_sorted_R3: assert property (@(posedge clk) disable iff (!rst_n)
                score_flat[(g-1)*SCORE_W +: SCORE_W] <= score_flat[g*SCORE_W +: SCORE_W]);
            assert_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
                vld_vec[g] |-> vld_vec[g-1]);
        end
    end

    assert_head_insert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !frame_done && (in_score < score_flat[SCORE_W-1:0]))
        |=> (score_flat[SCORE_W-1:0] == $past(in_score)));

    assert_clear_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (vld_vec == '0));

    assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> out_valid);

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> !out_valid);

endmodule

bind topk_score_tracker topk_checker #(.NUM_SLOTS(NUM_SLOTS), .SCORE_W(SCORE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_score   (in_score),
    .frame_done (frame_done),
    .out_valid  (out_valid),
    .score_flat (score_flat),
    .vld_vec    (vld_vec)
);

// File: tb/tb_topk_score_tracker.sv
module tb_topk_score_tracker;

    localparam int NS   = 3;
    localparam int SW   = 4;
    localparam int CW   = 3;
    localparam int MVW  = CW + 1;
    localparam int SMAX = (1 << SW) - 1;
    localparam int MAXN = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [SW-1:0]   in_score = '0;
    logic [CW-1:0]   in_x = '0, in_y = '0, ref_x = '0, ref_y = '0;
    logic            frame_done = 1'b0;
    logic            out_valid;
    logic [NS-1:0]   out_ok;
    logic [NS*MVW-1:0] out_dx, out_dy;

    int total = 0;
    int bad   = 0;
    int fs[MAXN], fx[MAXN], fy[MAXN];
    int n = 0;

    always #10 clk = ~clk;   // 50 MHz

    topk_score_tracker #(.NUM_SLOTS(NS), .SCORE_W(SW), .COORD_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_score(in_score),
        .in_x(in_x), .in_y(in_y), .ref_x(ref_x), .ref_y(ref_y),
        .frame_done(frame_done), .out_valid(out_valid), .out_ok(out_ok),
        .out_dx(out_dx), .out_dy(out_dy)
    );

    task automatic chk(string tag, int act_v, int exp_v);
        total++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    task automatic push(int s, int x, int y);
        @(negedge clk);
        in_valid = 1'b1;
        in_score = SW'(s);
        in_x     = CW'(x);
        in_y     = CW'(y);
        fs[n] = s; fx[n] = x; fy[n] = y;
        n++;
    endtask

    // close a frame and compare the ranked list with an arrival-order selection
    task automatic finish(string tag, int rx, int ry, bit collide);
        int  exp_ok[NS], exp_dx[NS], exp_dy[NS];
        bit  taken[MAXN];
        for (int i = 0; i < MAXN; i++) taken[i] = 1'b0;
        for (int r = 0; r < NS; r++) begin
            int best = -1;
            for (int i = 0; i < n; i++) begin
                if (!taken[i] && fs[i] < SMAX && (best < 0 || fs[i] < fs[best])) best = i;
            end
            if (best >= 0) begin
                taken[best] = 1'b1;
                exp_ok[r] = 1;
                exp_dx[r] = (fx[best] - rx) & ((1 << MVW) - 1);
                exp_dy[r] = (fy[best] - ry) & ((1 << MVW) - 1);
            end else begin
                exp_ok[r] = 0; exp_dx[r] = 0; exp_dy[r] = 0;
            end
        end
        @(negedge clk);
        in_valid   = collide;
        in_score   = '0;
        in_x       = CW'(7);
        in_y       = CW'(7);
        ref_x      = CW'(rx);
        ref_y      = CW'(ry);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        in_valid   = 1'b0;
        chk({tag, " R8 strobe"}, int'(out_valid), 1);
        for (int r = 0; r < NS; r++) begin
            chk({tag, " ok"}, int'(out_ok[r]), exp_ok[r]);
            chk({tag, " R6 dx"}, int'(out_dx[r*MVW +: MVW]), exp_dx[r]);
            chk({tag, " R6 dy"}, int'(out_dy[r*MVW +: MVW]), exp_dy[r]);
        end
        @(negedge clk);
        chk({tag, " R8 one cycle"}, int'(out_valid), 0);
        chk({tag, " R8 held"}, int'(out_dx[MVW-1:0]), exp_dx[0]);
        n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_ok", int'(out_ok), 0);
        chk("R1 out_dx", int'(out_dx), 0);
        chk("R1 out_dy", int'(out_dy), 0);
        rst_n = 1'b1;

        // R1: empty frame straight after reset reports no filled rank
        finish("R1 empty", 0, 0, 1'b0);

        // R4: descending costs push older entries down
        push(9, 1, 2); push(7, 2, 3); push(5, 3, 4); push(3, 4, 5); push(1, 5, 6);
        finish("R4 descending", 2, 2, 1'b0);

        // R3: ascending costs, first three kept in order
        push(1, 7, 0); push(2, 6, 1); push(3, 5, 2); push(4, 4, 3); push(5, 3, 4);
        finish("R3 ascending", 4, 4, 1'b0);

        // R5: equal costs keep earliest arrivals
        push(6, 0, 0); push(6, 1, 1); push(6, 2, 2); push(6, 3, 3); push(6, 4, 4);
        finish("R5 ties", 0, 7, 1'b0);

        // R5: mid-list tie lands behind the earlier equal entry
        push(2, 1, 1); push(8, 2, 2); push(8, 3, 3); push(5, 4, 4);
        finish("R5 mid tie", 3, 3, 1'b0);

        // R7: under-filled list
        push(4, 6, 1);
        push(9, 1, 6);
        finish("R7 partial", 7, 0, 1'b0);

        // R2: maximum cost never stored
        push(SMAX, 1, 1); push(SMAX, 2, 2); push(14, 3, 3); push(SMAX, 4, 4);
        finish("R2 max cost", 0, 0, 1'b0);

        // R9: beat colliding with done is ignored, next frame starts empty
        push(8, 1, 2); push(9, 2, 1);
        finish("R9 collide", 1, 1, 1'b1);
        push(10, 5, 5);
        finish("R9 cleared", 5, 5, 1'b0);

        // R6: random frames with signed displacement extremes
        for (int f = 0; f < 300; f++) begin
            int len = $urandom_range(12, 1);
            for (int k = 0; k < len; k++) begin
                push($urandom_range(SMAX, 0), $urandom_range(7, 0), $urandom_range(7, 0));
            end
            finish("R6 random", $urandom_range(7, 0), $urandom_range(7, 0), f[0]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule